// File: doc/BRIEF.md
# Privilege-Gated 64-bit Timebase Counter

This block keeps a 64-bit running count of elapsed time for a processor core. It can count in one of two ways. In per-cycle mode it adds one on every cycle in which the core clock is active, so its rate follows the core frequency. In constant-rate mode it adds one on each pulse of a reference tick, so each count stands for the same span of time whatever the core frequency does. The counter is off after reset and counts only once software turns it on.

A client reads the count with a one-cycle request. The response comes back on the next cycle as a high 32-bit half and a low 32-bit half. Both halves are taken from the same snapshot, so a carry between the halves can never produce a mixed value. Reads can be refused. A user-privilege read needs a permission bit. A separate block bit refuses reads at every privilege level. A refused read raises a fault strobe and returns no data.

Supervisor software can load a new count and write the four control bits. The same writes from user privilege have no effect. A resume clear input zeroes the count without touching the controls.

Top module: `tsc_unit`

## Requirements
- R1: After reset the count is zero and all control bits are zero, so counting is off. While counting is off, core clock activity leaves the count unchanged.
- R2: In per-cycle mode (control bit 1 = 0) with counting on (control bit 0 = 1), the count rises by one on every cycle in which `core_clk_act` is 1, and holds on other cycles.
- R3: In constant-rate mode (control bit 1 = 1) with counting on, the count rises by one on every cycle in which `ref_tick` is 1, and `core_clk_act` has no effect.
- R4: A read request in cycle N, if permitted, gives `rd_valid` in cycle N+1 with `rd_hi`/`rd_lo` equal to bits 63:32 and 31:0 of the count held in cycle N.
- R5: A read with `priv_sup` = 0 while the user permit (control bit 2) is 0 gives `rd_fault` and zero data. With the permit set, the same read succeeds.
- R6: While the read block (control bit 3) is 1, a read faults at both privilege levels.
- R7: `ld_we` with `priv_sup` = 1 replaces the count with `ld_val` on the next cycle, and wins over an increment in the same cycle. With `priv_sup` = 0, `ld_we` is ignored.
- R8: A mode change written in cycle N applies to increments from cycle N+1 on, and leaves the present count unchanged.
- R9: `resume_clr` zeroes the count on the next cycle, and wins over a load and an increment. Control bits are kept.
- R10: `rd_valid` and `rd_fault` are never both high. One of them is high in the cycle after each request, and neither is high otherwise.
- R11: `cfg_we` with `priv_sup` = 1 loads `cfg_wdata` into the control bits (bit 0 count on, bit 1 constant-rate, bit 2 user permit, bit 3 read block). With `priv_sup` = 0 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resume_clr | input | 1 | Clears the count after a resume |
| core_clk_act | input | 1 | Core clock active in this cycle |
| ref_tick | input | 1 | Single-cycle constant-rate reference pulse |
| priv_sup | input | 1 | Requester is at supervisor privilege |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 4 | Control bits to write |
| ld_we | input | 1 | Count load strobe |
| ld_val | input | 64 | Value to load into the count |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_fault | output | 1 | Read refused, one cycle after the request |
| rd_hi | output | 32 | Upper half of the snapshot |
| rd_lo | output | 32 | Lower half of the snapshot |

## Verification
A wrong count or a wrong control bit stays hidden until the next read. The bench therefore reads often, and one read is enough to expose the fault: a wrong value shows in `rd_hi`/`rd_lo`, and a wrong permission shows as `rd_fault` in place of `rd_valid` one cycle after the request. Loads near the 32-bit boundary put carries into the upper half, so a torn or late snapshot shows up as a mismatch in that half. Random runs that mix modes, ticks, loads and clears check each response against a model of the count that tracks every cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    // Control bits; the packed order makes count_on bit 0.
    typedef struct packed {
        logic rd_block;
        logic user_ok;
        logic const_mode;
        logic count_on;
    } tsc_cfg_t;
endpackage

// File: rtl/tsc_cfg.sv
module tsc_cfg
    import tsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  tsc_cfg_t wr_data,
    output tsc_cfg_t cfg_q
);
    tsc_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/tsc_count.sv
module tsc_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (ld)  cnt_d = ld_val;
        else if (inc) cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tsc_rdport.sv
module tsc_rdport #(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              allow,
    input  logic [CNT_W-1:0]  snap,
    output logic              valid_q,
    output logic              fault_q,
    output logic [HALF_W-1:0] hi_q,
    output logic [HALF_W-1:0] lo_q
);
    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req) begin
            rsp_d.valid = allow;
            rsp_d.fault = !allow;
            if (allow) begin
                rsp_d.hi = snap[CNT_W-1:HALF_W];
                rsp_d.lo = snap[HALF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign valid_q = rsp_q.valid;
    assign fault_q = rsp_q.fault;
    assign hi_q    = rsp_q.hi;
    assign lo_q    = rsp_q.lo;
endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
    import tsc_pkg::*;
#(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resume_clr,
    input  logic              core_clk_act,
    input  logic              ref_tick,
    input  logic              priv_sup,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_wdata,
    input  logic              ld_we,
    input  logic [CNT_W-1:0]  ld_val,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic              rd_fault,
    output logic [HALF_W-1:0] rd_hi,
    output logic [HALF_W-1:0] rd_lo
);
    tsc_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             rd_allow;

    // Increment source chosen by the registered mode bit (R2, R3, R8).
    always_comb begin
        step = 1'b0;
        if (cfg_q.count_on) step = cfg_q.const_mode ? ref_tick : core_clk_act;
    end

    // Read permission (R5, R6).
    assign rd_allow = !cfg_q.rd_block && (priv_sup || cfg_q.user_ok);

    tsc_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && priv_sup),
        .wr_data (tsc_cfg_t'(cfg_wdata)),
        .cfg_q   (cfg_q)
    );

    tsc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (resume_clr),
        .ld     (ld_we && priv_sup),
        .ld_val (ld_val),
        .inc    (step),
        .cnt_q  (cnt_q)
    );

    tsc_rdport #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rd_req),
        .allow   (rd_allow),
        .snap    (cnt_q),
        .valid_q (rd_valid),
        .fault_q (rd_fault),
        .hi_q    (rd_hi),
        .lo_q    (rd_lo)
    );
endmodule

// File: rtl/tsc_unit_chk.sv
module tsc_unit_chk #(
    parameter int CNT_W = 64,
    localparam int HALF_W = CNT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              resume_clr,
    input logic              priv_sup,
    input logic              ld_we,
    input logic [CNT_W-1:0]  ld_val,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              rd_fault,
    input logic [HALF_W-1:0] rd_hi,
    input logic [HALF_W-1:0] rd_lo,
    input logic [CNT_W-1:0]  cnt,
    input logic [3:0]        cfg
);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_fault));

    assert_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid || rd_fault));

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !(rd_valid || rd_fault));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_clr |=> (cnt == '0));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && priv_sup && !resume_clr) |=> (cnt == $past(ld_val)));

    assert_user_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !priv_sup && !cfg[2]) |=> rd_fault);

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cfg[3]) |=> rd_fault);

    assert_fault_nodata_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_hi == '0 && rd_lo == '0));
endmodule

bind tsc_unit tsc_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .resume_clr (resume_clr),
    .priv_sup   (priv_sup),
    .ld_we      (ld_we),
    .ld_val     (ld_val),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_fault   (rd_fault),
    .rd_hi      (rd_hi),
    .rd_lo      (rd_lo),
    .cnt        (cnt_q),
    .cfg        (cfg_q)
);

// File: tb/tb_tsc_unit.sv
module tb_tsc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        resume_clr = 1'b0, core_clk_act = 1'b0, ref_tick = 1'b0;
    logic        priv_sup = 1'b1, cfg_we = 1'b0, ld_we = 1'b0, rd_req = 1'b0;
    logic [3:0]  cfg_wdata = '0;
    logic [63:0] ld_val = '0;
    logic        rd_valid, rd_fault;
    logic [31:0] rd_hi, rd_lo;

    int tests = 0, fails = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    tsc_unit dut (.*);

    // Reference model: bit0 on, bit1 const, bit2 user permit, bit3 block
    logic [63:0] m_cnt;
    logic [3:0]  m_cfg;
    logic        e_v, e_f;
    logic [63:0] e_data;

    function automatic logic permit(logic [3:0] c, logic sup);
        return !c[3] && (sup || c[2]);
    endfunction

    function automatic logic [63:0] next_cnt(logic [63:0] c, logic [3:0] g,
        logic clr, logic ld, logic sup, logic [63:0] lv, logic core, logic tk);
        if (clr) return 64'd0;
        if (ld && sup) return lv;
        if (g[0] && (g[1] ? tk : core)) return c + 64'd1;
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_cfg = '0; e_v = 0; e_f = 0; e_data = '0;
        end else begin
            e_v = rd_req && permit(m_cfg, priv_sup);
            e_f = rd_req && !permit(m_cfg, priv_sup);
            e_data = e_v ? m_cnt : 64'd0;
            m_cnt = next_cnt(m_cnt, m_cfg, resume_clr, ld_we, priv_sup, ld_val,
                             core_clk_act, ref_tick);
            if (cfg_we && priv_sup) m_cfg = cfg_wdata;
        end
    end

    task automatic check(bit ok, string t, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_valid == e_v && rd_fault == e_f, "R10", "valid/fault",
                  {62'd0, rd_valid, rd_fault}, {62'd0, e_v, e_f});
            if (e_v) check({rd_hi, rd_lo} == e_data, tag, "read data",
                           {rd_hi, rd_lo}, e_data);
            if (e_f) check({rd_hi, rd_lo} == 64'd0, tag, "fault data",
                           {rd_hi, rd_lo}, 64'd0);
        end
    end

    task automatic idle();
        {resume_clr, cfg_we, ld_we, rd_req} = '0;
    endtask

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        idle();
    endtask

    task automatic wcfg(logic [3:0] v, logic sup);
        cfg_we = 1; cfg_wdata = v; priv_sup = sup; cyc(); priv_sup = 1;
    endtask

    task automatic rd(logic sup);
        rd_req = 1; priv_sup = sup; cyc(); priv_sup = 1;
    endtask

    initial begin
        #(8 * 100000);
        tests++; fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: count zero and disabled after reset
        check(rd_valid == 0 && rd_fault == 0, "R1", "idle outputs", {rd_valid, rd_fault}, 0);
        core_clk_act = 1; ref_tick = 1;
        cyc(6);
        tag = "R1"; rd(1); cyc();
        // R11: user-level config write ignored
        tag = "R11"; wcfg(4'b0001, 0); cyc(4); rd(1); cyc();
        // R2: per-cycle mode follows core activity
        tag = "R2"; ref_tick = 0; wcfg(4'b0001, 1);
        for (int i = 0; i < 20; i++) begin core_clk_act = i[0] | i[2]; cyc(); end
        rd(1); cyc();
        // R3: constant-rate mode follows ref_tick only
        tag = "R3"; wcfg(4'b0011, 1); core_clk_act = 1;
        for (int i = 0; i < 20; i++) begin ref_tick = (i % 3 == 0); cyc(); end
        ref_tick = 0; rd(1); cyc();
        // R8: mode change keeps the count, applies next cycle
        tag = "R8"; ref_tick = 0; core_clk_act = 1;
        rd_req = 1; cfg_we = 1; cfg_wdata = 4'b0001; cyc();
        rd(1); rd(1); cyc();
        // R7: load, carry across halves, load beats increment, user load ignored
        tag = "R7"; ld_we = 1; ld_val = 64'h0000_0000_FFFF_FFFD; cyc();
        rd(1); rd(1); rd(1); rd(1);
        ld_we = 1; ld_val = 64'h1234_5678_9ABC_DEF0; priv_sup = 0; cyc(); priv_sup = 1;
        rd(1);
        tag = "R4"; core_clk_act = 0; rd(1); cyc();
        // R5: user read permission
        tag = "R5"; rd(0); cyc(); wcfg(4'b0101, 1); rd(0); cyc();
        // R6: read block faults at both levels
        tag = "R6"; wcfg(4'b1101, 1); rd(0); rd(1); cyc(); wcfg(4'b0101, 1);
        // R9: resume clear beats load and increment; controls kept
        tag = "R9"; core_clk_act = 1; resume_clr = 1; ld_we = 1; ld_val = 64'hFF; cyc();
        rd(0); cyc(2); rd(1); cyc();
        // Random mix
        tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            core_clk_act = $urandom_range(0, 3) != 0;
            ref_tick     = $urandom_range(0, 4) == 0;
            priv_sup     = $urandom_range(0, 3) != 0;
            rd_req       = $urandom_range(0, 2) == 0;
            cfg_we       = $urandom_range(0, 40) == 0;
            cfg_wdata    = {($urandom_range(0, 5) == 0), 3'($urandom)};
            ld_we        = $urandom_range(0, 60) == 0;
            ld_val       = {32'($urandom), 30'h3FFF_FFFF, 2'($urandom)};
            resume_clr   = $urandom_range(0, 150) == 0;
            @(negedge clk);
        end
        idle(); priv_sup = 1; cyc(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule